// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer

This block is a clocked sequencer that fetches bytes from an external asynchronous 32K x 8 ROM for a simple host port. When the host raises a request, the block puts the address on the ROM pins and enables the part. It then waits a set number of clock cycles for the access to finish, captures the data byte and returns it with a one-cycle valid strobe.

The block handles a single read or a burst of reads. In a burst, the chip select, chip enable and output enable all stay active, and only the address moves. Each new address starts a fresh access. Address changes are spaced by a minimum word window. When the last word of a read is captured, the block drops all three controls. It then stays busy until the slower of the two turn-off delays has passed, so the ROM has released the data bus before another request is accepted.

All timing values are parameters counted in clock cycles. `ACC_CYC` is the address-to-data access time and is at least 1. `CYC_CYC` is the minimum read cycle and is at least `ACC_CYC`. `CS_OFF_CYC` and `CE_OFF_CYC` are the turn-off delays of the two enables. The word window is W = max(`CYC_CYC`, `ACC_CYC`+1) cycles. The turn-off wait is T = max(`CS_OFF_CYC`, `CE_OFF_CYC`, 1) cycles.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `rom_cs_no`=1, `rom_ce_o`=0, `rom_oe_no`=1, `rom_addr_o`=0, `busy_o`=0 and `rvalid_o`=0. Whenever `busy_o` is 0, the three controls are inactive.
- R2: When idle, a clock edge that samples `req_i`=1 does four things on that same edge: it loads `addr_i` onto `rom_addr_o`, drives `rom_cs_no` low, drives `rom_ce_o` high and drives `rom_oe_no` low. `busy_o` is 1 from that edge on.
- R3: The data byte is sampled from `rom_data_i` exactly `ACC_CYC` clock edges after the edge that changed the address. `rdata_o` and `rvalid_o`=1 appear on that edge, and `rvalid_o` lasts one cycle.
- R4: At the edge that ends a word window (W edges after the address change), if `req_i`=1 and `burst_i`=1 are both sampled, `addr_i` becomes the next address. The three controls stay active with no gap. After each `rvalid_o` pulse, the host presents the next word's inputs before the next rising edge.
- R5: While the controls stay active, successive address changes are exactly W clock cycles apart.
- R6: If `req_i` or `burst_i` is 0 at the edge that ends a word window, all three controls go inactive on that edge.
- R7: After the controls go inactive, `busy_o` stays 1 for exactly T cycles and then falls. No request is accepted and no control is asserted again during that time.
- R8: While a word is in progress, changes on `addr_i`, `req_i` and `burst_i` before the window-ending edge have no effect on `rom_addr_o` or on the controls.
- R9: `rom_oe_no` is low only while `rom_cs_no` is low and `rom_ce_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host read request |
| addr_i | input | 15 | Host byte address |
| burst_i | input | 1 | Continue the burst with the next address |
| busy_o | output | 1 | Read or turn-off wait in progress |
| rdata_o | output | 8 | Captured byte |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| rom_addr_o | output | 15 | ROM address pins |
| rom_cs_no | output | 1 | ROM chip select, active low |
| rom_ce_o | output | 1 | ROM chip enable, active high |
| rom_oe_no | output | 1 | ROM output enable, active low |
| rom_data_i | input | 8 | ROM data pins |

## Verification
Several rules are checked by assertions on every cycle. The output enable is asserted only while the chip is selected and enabled. The controls are quiet whenever the block is idle. The address holds steady during a word and moves only at the end of a window. A falling enable is always followed by busy time, and the valid strobe never lasts two cycles. Other behaviour shows only in the bench's scenarios, which use a ROM model that returns wrong data until the address has been stable for the access time. These scenarios show that the captured bytes are correct and arrive in order, that the capture comes exactly `ACC_CYC` edges after the address change, that bursts keep to exact window spacing, and that the turn-off wait has the exact length.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_OFF} rd_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rom_rd_cnt.sv
module rom_rd_cnt #(
  parameter int unsigned MAX_VAL = 7,
  localparam int unsigned W = $clog2(MAX_VAL + 2)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (cnt_o != W'(MAX_VAL + 1)) cnt_o <= cnt_o + 1'b1;
  end

  assert_clr_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/rom_rd_bus.sv
module rom_rd_bus #(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          release_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          cs_no,
  output logic          ce_o,
  output logic          oe_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cs_no  <= 1'b1;
      ce_o   <= 1'b0;
      oe_no  <= 1'b1;
    end else if (load_i) begin
      // enables settle no later than the address edge
      addr_o <= addr_i;
      cs_no  <= 1'b0;
      ce_o   <= 1'b1;
      oe_no  <= 1'b0;
    end else if (release_i) begin
      cs_no  <= 1'b1;
      ce_o   <= 1'b0;
      oe_no  <= 1'b1;
    end
  end

  assert_oe_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (!cs_no && ce_o));
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o));
endmodule

// File: rtl/rom_rd_cap.sv
module rom_rd_cap #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= data_i;
    end
  end

  assert_pulse_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int unsigned AW         = 15,
  parameter int unsigned DW         = 8,
  parameter int unsigned ACC_CYC    = 3,
  parameter int unsigned CYC_CYC    = 5,
  parameter int unsigned CS_OFF_CYC = 2,
  parameter int unsigned CE_OFF_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          burst_i,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] rom_addr_o,
  output logic          rom_cs_no,
  output logic          rom_ce_o,
  output logic          rom_oe_no,
  input  logic [DW-1:0] rom_data_i
);
  // window ends at least one cycle after capture so the host can follow rvalid
  localparam int unsigned END_CNT = max2(CYC_CYC, ACC_CYC + 1) - 1;
  localparam int unsigned OFF_CNT = max2(max2(CS_OFF_CYC, CE_OFF_CYC), 1) - 1;
  localparam int unsigned CNT_MAX = max2(END_CNT, OFF_CNT);
  localparam int unsigned CW      = $clog2(CNT_MAX + 2);

  rd_state_e     state_q, state_d;
  logic [CW-1:0] cnt;
  logic          load, release_b, cap;

  rom_rd_cnt #(.MAX_VAL(CNT_MAX)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load | release_b),
    .cnt_o (cnt)
  );

  rom_rd_bus #(.AW(AW)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .release_i(release_b),
    .addr_i   (addr_i),
    .addr_o   (rom_addr_o),
    .cs_no    (rom_cs_no),
    .ce_o     (rom_ce_o),
    .oe_no    (rom_oe_no)
  );

  rom_rd_cap #(.DW(DW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .data_i  (rom_data_i),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    release_b = 1'b0;
    cap       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        load    = 1'b1;
        state_d = ST_ACCESS;
      end
      ST_ACCESS: begin
        cap = (cnt == CW'(ACC_CYC - 1));
        if (cnt == CW'(END_CNT)) begin
          if (req_i && burst_i) begin
            load = 1'b1;
          end else begin
            release_b = 1'b1;
            state_d   = ST_OFF;
          end
        end
      end
      ST_OFF: if (cnt == CW'(OFF_CNT)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rom_cs_no && !rom_ce_o && rom_oe_no));
  assert_off_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rom_ce_o) |-> busy_o);
  assert_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_cs_no && $past(!rom_cs_no) && (rom_addr_o != $past(rom_addr_o)))
      |-> ($past(cnt) == CW'(END_CNT)));
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> (busy_o && !rom_cs_no && rom_ce_o && !rom_oe_no));
endmodule

// File: tb/tb_rom_rd_ctrl.sv
module tb_rom_rd_ctrl;
  localparam int unsigned ACC = 3, CYC = 5, CSO = 2, CEO = 3;
  localparam int unsigned WIN = (CYC > ACC + 1) ? CYC : ACC + 1;
  localparam int unsigned TOFF = (CSO > CEO) ? ((CSO > 1) ? CSO : 1) : ((CEO > 1) ? CEO : 1);

  logic clk = 0, rst_n = 0;
  logic req = 0, burst = 0;
  logic [14:0] addr = '0;
  logic busy, rvalid, cs_n, ce, oe_n;
  logic [7:0] rdata, rom_data;
  logic [14:0] rom_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rom_rd_ctrl #(.ACC_CYC(ACC), .CYC_CYC(CYC), .CS_OFF_CYC(CSO), .CE_OFF_CYC(CEO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .burst_i(burst),
    .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid), .rom_addr_o(rom_addr),
    .rom_cs_no(cs_n), .rom_ce_o(ce), .rom_oe_no(oe_n), .rom_data_i(rom_data));

  function automatic logic [7:0] rom_word(logic [14:0] a);
    return 8'(a) ^ 8'(a >> 7) ^ 8'h3C;
  endfunction

  // ROM model: correct data only once the address has been stable for the access time
  int unsigned age = 0;
  logic age_act = 0;
  logic [14:0] age_addr = '0;
  wire act = !cs_n && ce && !oe_n;
  always @(negedge clk) begin
    if (!act || !age_act || rom_addr != age_addr) age <= 0;
    else if (age < 1000) age <= age + 1;
    age_act  <= act;
    age_addr <= rom_addr;
  end
  assign rom_data = (act && age >= ACC - 1) ? rom_word(rom_addr) : ~rom_word(rom_addr);

  task automatic chk(input bit ok, input string req_tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act_v, exp_v);
    end
  endtask

  task automatic run_txn(input int n, input logic [14:0] a0, input bit end_req);
    logic [14:0] a[4];
    int k = 0, cur = 0, since = 0, off = 0;
    bit prev_act = 0, prev_rv = 0, ending = 0, first = 1;
    logic [14:0] prev_addr = '0;
    a[0] = a0;
    for (int i = 1; i < 4; i++) a[i] = 15'($urandom);
    @(negedge clk);
    req = 1; addr = a[0]; burst = (n > 1);
    for (int it = 0; it < 200; it++) begin
      @(negedge clk);
      if (first) begin
        chk(act && busy && rom_addr == a[0], "R2", int'(rom_addr), int'(a[0]));
        first = 0;
      end
      chk(oe_n || (!cs_n && ce), "R9", int'(oe_n), 1);
      chk(!(rvalid && prev_rv), "R3 pulse", int'(rvalid), 0);
      if (ending) begin
        chk(!act, "R7 no reassert", int'(act), 0);
        if (!busy) begin
          chk(off == TOFF, "R7 wait", off, TOFF);
          break;
        end
        off++;
      end else if (act) begin
        if (prev_act && rom_addr != prev_addr) begin
          chk(since + 1 == WIN, "R5 spacing", since + 1, WIN);
          cur++;
          since = 0;
        end else if (prev_act) since++;
        chk(cur < n && rom_addr == a[cur], "R8 addr", int'(rom_addr), int'(a[cur]));
        if (rvalid) begin
          chk(since == ACC, "R3 timing", since, ACC);
          chk(rdata == rom_word(a[k]), "R3 data", int'(rdata), int'(rom_word(a[k])));
          k++;
          if (k < n) begin req = 1; burst = 1; addr = a[k]; end
          else begin req = end_req; burst = 0; addr = 15'($urandom); end
        end else if (since < ACC) begin
          req = 1'($urandom); burst = 1'($urandom); addr = 15'($urandom);
        end
      end else if (prev_act) begin
        chk(k == n, "R6 end", k, n);
        chk(busy, "R7 busy", int'(busy), 1);
        ending = 1;
        off = 1;
      end
      if (k == n && n > 1 && rvalid) chk(act, "R4 no gap", int'(act), 1);
      prev_act = act; prev_addr = rom_addr; prev_rv = rvalid;
    end
    chk(ending && !busy, "R7 done", int'(busy), 0);
    req = 0; burst = 0;
    chk(!busy && cs_n && !ce && oe_n, "R1 idle quiet", int'(cs_n), 1);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n && !ce && oe_n && rom_addr == 0 && !busy && !rvalid, "R1 in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !ce && oe_n && rom_addr == 0 && !busy && !rvalid, "R1 after reset", int'(rom_addr), 0);
    // R2/R3: single read, low and high address corners
    run_txn(1, 15'h0000, 0);
    run_txn(1, 15'h7FFF, 0);
    // R4/R5: full burst, request left high at the end (R6 with burst low)
    run_txn(4, 15'h1234, 1);
    run_txn(2, 15'h7FFE, 0);
    // random mix
    for (int t = 0; t < 40; t++) run_txn(1 + int'($urandom_range(0, 3)), 15'($urandom), 1'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule